// File: doc/BRIEF.md
# Operand Width Extension Unit

This unit sits in front of the ALU of a single-address 32-bit RISC core and widens every narrow operand to the native 32-bit width. A raw value of 8, 16 or 32 bits arrives from memory or from the 8-bit immediate field of a 16-bit instruction. A class flag says whether the consuming operation is arithmetic or logical. Arithmetic operations get a sign-extended value. Logical operations get a zero-extended value. Longword values pass through untouched.

Constants wider than 8 bits do not fit in the instruction word, so the core keeps them in literal pools near the code and fetches them with a PC-relative load. The unit also computes that pool address from the program counter and an 8-bit unsigned displacement. The scale is four for longword constants, with the PC first aligned down to a 4-byte boundary. The scale is two for word constants, and the PC is used as it is.

Both results are registered. Inputs sampled on one rising clock edge appear on the outputs after that edge. A synchronous active-high reset clears both outputs.

Top module: `opx_unit`

## Requirements
- R1: With `rst` high at a rising edge, both `operand_out` and `lit_addr_out` read 0 after that edge.
- R2: With `size_sel` = 2'b10 (longword), `operand_out` equals `raw_in` unchanged, for either operation class.
- R3: With `size_sel` = 2'b00 (byte) and `logic_op` = 0 (arithmetic), `operand_out` is bits 7:0 of `raw_in` sign-extended to 32 bits.
- R4: With `size_sel` = 2'b00 and `logic_op` = 1 (logical), `operand_out` is bits 7:0 of `raw_in` zero-extended to 32 bits.
- R5: With `size_sel` = 2'b01 (word) and `logic_op` = 0, `operand_out` is bits 15:0 of `raw_in` sign-extended to 32 bits.
- R6: With `size_sel` = 2'b01 and `logic_op` = 1, `operand_out` is bits 15:0 of `raw_in` zero-extended to 32 bits.
- R7: The reserved code `size_sel` = 2'b11 passes `raw_in` through unchanged.
- R8: With `lit_long` = 1, `lit_addr_out` equals (`pc_in` with bits 1:0 cleared) plus `disp_in`×4, where `disp_in` is treated as unsigned.
- R9: With `lit_long` = 0, `lit_addr_out` equals `pc_in` plus `disp_in`×2, where `disp_in` is treated as unsigned.
- R10: The outputs change only at a rising clock edge. They reflect the inputs sampled at the most recent edge, and input changes between edges do not show on the outputs.
- R11: For byte and word sizes, bits of `raw_in` above the selected width have no effect on `operand_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 32 | Raw operand, right-aligned |
| size_sel | input | 2 | Operand width: 00 byte, 01 word, 10 longword, 11 reserved (pass) |
| logic_op | input | 1 | 1 = logical operation (zero extend), 0 = arithmetic (sign extend) |
| pc_in | input | 32 | Program counter of the literal load |
| disp_in | input | 8 | Unsigned literal-pool displacement |
| lit_long | input | 1 | 1 = longword constant, 0 = word constant |
| operand_out | output | 32 | Extended operand, registered |
| lit_addr_out | output | 32 | Literal-pool effective address, registered |

## Verification
On every cycle after reset, the assertions compare each output with the inputs sampled one edge earlier. The comparison covers all four size codes in both operation classes and both literal-pool scalings, and it also checks that reset clears both outputs. Only the bench scenarios can show particular boundary values: the sign bit at 0x80 and 0x8000, unaligned PCs and the largest displacement. They also show that input changes between edges do not leak to the outputs, and that junk in the upper bits of a narrow operand is discarded.

// File: rtl/opx_pkg.sv
package opx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } opx_size_e;
endpackage

// File: rtl/opx_extend.sv
module opx_extend #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0]    raw,
  input  opx_pkg::opx_size_e   size,
  input  logic                 logic_op,
  output logic [DATA_W-1:0]    ext
);
  localparam int BYTE_PAD = DATA_W - BYTE_W;
  localparam int HALF_PAD = DATA_W - HALF_W;

  logic byte_fill;
  logic half_fill;
  logic [DATA_W-1:0] byte_val;
  logic [DATA_W-1:0] half_val;

  assign byte_fill = ~logic_op & raw[BYTE_W-1];
  assign half_fill = ~logic_op & raw[HALF_W-1];
  assign byte_val  = {{BYTE_PAD{byte_fill}}, raw[BYTE_W-1:0]};
  assign half_val  = {{HALF_PAD{half_fill}}, raw[HALF_W-1:0]};

  always_comb begin
    unique case (size)
      opx_pkg::SZ_BYTE: ext = byte_val;
      opx_pkg::SZ_WORD: ext = half_val;
      default:          ext = raw;
    endcase
  end
endmodule

// File: rtl/opx_litaddr.sv
module opx_litaddr #(
  parameter int DATA_W    = 32,
  parameter int DISP_W    = 8,
  parameter int LONG_SHFT = 2,
  parameter int HALF_SHFT = 1
) (
  input  logic [DATA_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              is_long,
  output logic [DATA_W-1:0] addr
);
  localparam int DISP_PAD = DATA_W - DISP_W;
  localparam logic [DATA_W-1:0] LONG_MASK = ~((DATA_W'(1) << LONG_SHFT) - DATA_W'(1));

  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] offset;

  assign disp_ext = {{DISP_PAD{1'b0}}, disp};
  assign base     = is_long ? (pc & LONG_MASK) : pc;
  assign offset   = is_long ? (disp_ext << LONG_SHFT) : (disp_ext << HALF_SHFT);
  assign addr     = base + offset;
endmodule

// File: rtl/opx_unit.sv
module opx_unit #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] raw_in,
  input  logic [1:0]        size_sel,
  input  logic              logic_op,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DISP_W-1:0] disp_in,
  input  logic              lit_long,
  output logic [DATA_W-1:0] operand_out,
  output logic [DATA_W-1:0] lit_addr_out
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] ext_d;
  logic [DATA_W-1:0] addr_d;

  opx_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) i_extend (
    .raw      (raw_in),
    .size     (opx_pkg::opx_size_e'(size_sel)),
    .logic_op (logic_op),
    .ext      (ext_d)
  );

  opx_litaddr #(.DATA_W(DATA_W), .DISP_W(DISP_W)) i_litaddr (
    .pc      (pc_in),
    .disp    (disp_in),
    .is_long (lit_long),
    .addr    (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand_out  <= '0;
      lit_addr_out <= '0;
    end else begin
      operand_out  <= ext_d;
      lit_addr_out <= addr_d;
    end
  end
endmodule

// File: rtl/opx_unit_chk.sv
module opx_unit_chk #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] raw_in,
  input logic [1:0]        size_sel,
  input logic              logic_op,
  input logic [DATA_W-1:0] pc_in,
  input logic [DISP_W-1:0] disp_in,
  input logic              lit_long,
  input logic [DATA_W-1:0] operand_out,
  input logic [DATA_W-1:0] lit_addr_out
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (operand_out == '0 && lit_addr_out == '0));

  // R2, R7
  a_r2_wide_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(size_sel[1])) |-> operand_out == $past(raw_in));

  // R3, R4
  a_r3_byte_ext: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(size_sel) == 2'b00) |->
      (operand_out[7:0] == $past(raw_in[7:0]) &&
       operand_out[DATA_W-1:8] == {(DATA_W-8){~$past(logic_op) & $past(raw_in[7])}}));

  // R5, R6
  a_r5_word_ext: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(size_sel) == 2'b01) |->
      (operand_out[15:0] == $past(raw_in[15:0]) &&
       operand_out[DATA_W-1:16] == {(DATA_W-16){~$past(logic_op) & $past(raw_in[15])}}));

  // R8
  a_r8_long_pool: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lit_long)) |->
      (lit_addr_out[1:0] == 2'b00 &&
       lit_addr_out - {$past(pc_in[DATA_W-1:2]), 2'b00} == DATA_W'($past(disp_in)) * 4));

  // R9
  a_r9_word_pool: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lit_long)) |->
      (lit_addr_out - $past(pc_in) == DATA_W'($past(disp_in)) * 2));
endmodule

bind opx_unit opx_unit_chk #(.DATA_W(DATA_W), .DISP_W(DISP_W)) i_opx_unit_chk (
  .clk(clk), .rst(rst), .raw_in(raw_in), .size_sel(size_sel), .logic_op(logic_op),
  .pc_in(pc_in), .disp_in(disp_in), .lit_long(lit_long),
  .operand_out(operand_out), .lit_addr_out(lit_addr_out)
);

// File: tb/test_opx_unit.sv
module test_opx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] raw_in = '0;
  logic [1:0]  size_sel = 2'b10;
  logic        logic_op = 1'b0;
  logic [31:0] pc_in = '0;
  logic [7:0]  disp_in = '0;
  logic        lit_long = 1'b0;
  logic [31:0] operand_out;
  logic [31:0] lit_addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opx_unit i_opx_unit (
    .clk(clk), .rst(rst), .raw_in(raw_in), .size_sel(size_sel), .logic_op(logic_op),
    .pc_in(pc_in), .disp_in(disp_in), .lit_long(lit_long),
    .operand_out(operand_out), .lit_addr_out(lit_addr_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge register, sample at next falling edge
  task automatic apply_op(input logic [31:0] r, input logic [1:0] sz, input logic lg);
    @(negedge clk);
    raw_in = r; size_sel = sz; logic_op = lg;
    @(negedge clk);
  endtask

  task automatic apply_lit(input logic [31:0] pc, input logic [7:0] d, input logic lg);
    @(negedge clk);
    pc_in = pc; disp_in = d; lit_long = lg;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 operand", operand_out, 32'h0);
    check("R1 litaddr", lit_addr_out, 32'h0);
  endtask

  task automatic t_long;
    apply_op(32'hDEAD_BEEF, 2'b10, 1'b0); check("R2 arith", operand_out, 32'hDEAD_BEEF);
    apply_op(32'h8000_0001, 2'b10, 1'b1); check("R2 logic", operand_out, 32'h8000_0001);
  endtask

  task automatic t_byte;
    apply_op(32'h0000_0080, 2'b00, 1'b0); check("R3 neg", operand_out, 32'hFFFF_FF80);
    apply_op(32'h0000_007F, 2'b00, 1'b0); check("R3 pos", operand_out, 32'h0000_007F);
    apply_op(32'h0000_00FF, 2'b00, 1'b1); check("R4 zero", operand_out, 32'h0000_00FF);
  endtask

  task automatic t_word;
    apply_op(32'h0000_8000, 2'b01, 1'b0); check("R5 neg", operand_out, 32'hFFFF_8000);
    apply_op(32'h0000_7FFF, 2'b01, 1'b0); check("R5 pos", operand_out, 32'h0000_7FFF);
    apply_op(32'h0000_9234, 2'b01, 1'b1); check("R6 zero", operand_out, 32'h0000_9234);
  endtask

  task automatic t_reserved;
    apply_op(32'h1234_5680, 2'b11, 1'b0); check("R7 rsvd arith", operand_out, 32'h1234_5680);
    apply_op(32'hF000_00F0, 2'b11, 1'b1); check("R7 rsvd logic", operand_out, 32'hF000_00F0);
  endtask

  task automatic t_upper_junk;
    apply_op(32'hABCD_1280, 2'b00, 1'b0); check("R11 byte arith", operand_out, 32'hFFFF_FF80);
    apply_op(32'hABCD_1280, 2'b00, 1'b1); check("R11 byte logic", operand_out, 32'h0000_0080);
    apply_op(32'h5555_F00D, 2'b01, 1'b1); check("R11 word logic", operand_out, 32'h0000_F00D);
  endtask

  task automatic t_pool;
    apply_lit(32'h0000_1003, 8'hFF, 1'b1); check("R8 unaligned max", lit_addr_out, 32'h0000_13FC);
    apply_lit(32'h0000_2000, 8'h00, 1'b1); check("R8 zero disp", lit_addr_out, 32'h0000_2000);
    apply_lit(32'h0000_1003, 8'h10, 1'b0); check("R9 word", lit_addr_out, 32'h0000_1023);
    apply_lit(32'hFFFF_FFFE, 8'h01, 1'b0); check("R9 wrap", lit_addr_out, 32'h0000_0000);
  endtask

  task automatic t_timing;
    apply_op(32'h0000_0011, 2'b10, 1'b0);
    @(negedge clk);
    raw_in = 32'h0000_0022;
    #1;
    check("R10 hold before edge", operand_out, 32'h0000_0011);
    @(negedge clk);
    check("R10 update after edge", operand_out, 32'h0000_0022);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_long();
    t_byte();
    t_word();
    t_reserved();
    t_upper_junk();
    t_pool();
    t_timing();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule